// File: doc/BRIEF.md
# Binary Seconds Counter with Alarm

This block keeps wall time as a plain binary count of seconds. A one-cycle reference enable input stands in for the slow reference clock. A programmable divider counts those pulses and emits one seconds tick per period. Each tick advances a 62-bit counter. Software sets the time in two steps. It first writes the new value into staging registers, then issues an upload command in the shared control register. Start and stop commands in the same register gate the counting.

An alarm value of 43 bits is compared with the live count under a 62-bit bit mask. Only the bit positions where the mask holds a one take part in the comparison. On a match a sticky match flag is set. The interrupt output follows that flag when the alarm is armed and wake is enabled. The mode register chooses what the counter does after a match: keep counting, restart from zero, or halt.

Access is through a simple 32-bit bus with a byte offset address, a write strobe and a read strobe. Read data appears on the cycle after the read strobe and holds until the next read.

Top module: `rtc_seconds_core`

## Requirements
- R1: After reset, the control word reads 0, the mode word reads 0, the seconds count reads 0, both compare mask words read as all ones (0xFFFFFFFF at 0x14, 0x3FFFFFFF at 0x18), and irq is low.
- R2: The divider limit is held in 26 bits (offset 0x08, bits 25:0, upper bits read 0). While running, the counter advances by one for every limit+1 cycles in which ref_en is high.
- R3: A control write (offset 0x00) with bit 5 set loads the staged value into the counter and clears the divider count. The staged low half is written at 0x20 (bits 31:0) and the staged high half at 0x24 (bits 29:0). Control bit 5 then reads 1 from the next cycle until a control write with bit 5 clear.
- R4: A control write with bit 0 set and bit 1 clear starts counting. Bit 1 stops counting and wins over bit 0. A control write with neither bit leaves the run state alone. Control bit 0 reads 1 while running, and a stopped counter holds its value.
- R5: A control write with bit 4 set clears the counter and the divider count. It takes priority over bit 5 in the same write.
- R6: A read of 0x20 returns count bits 31:0 and captures count bits 61:32 in the same cycle. A later read of 0x24 returns that captured half. Read data is valid the cycle after the read strobe.
- R7: While running, if the count equals the zero-extended alarm in every bit where the mask is 1, control bit 7 is set. The alarm is written at 0x0C (bits 31:0) and 0x10 (bits 10:0). The mask is written at 0x14 (bits 31:0) and 0x18 (bits 29:0). Bit 7 stays set until an alarm-off command.
- R8: irq is high exactly when the match flag is set, the alarm is armed, and mode bit 1 (wake enable) is 1. Control bit 2 arms the alarm. Control bit 3 disarms it and clears the match flag, and bit 3 wins over bit 2.
- R9: With wake enable set and mode bit 3 (continue) set, the counter keeps counting through a match.
- R10: With wake enable set and mode bit 2 (restart) set, a match clears the counter to zero and counting goes on. Mode bit 2 takes priority over mode bit 3.
- R11: With wake enable set and mode bits 2 and 3 both clear, a match halts the counter at the matching value and clears the run state. Without wake enable, a match does not change counting.
- R12: Control bits 6, 8, 9 and 10 have no effect and read back 0. Mode bit 0 is stored but has no effect. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference pulse, one cycle per reference period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_rd |
| irq | output | 1 | Alarm interrupt, level |

## Verification
The assertions assume that the bus never raises the write and read strobes in the same cycle. They also assume that a write lasts a single cycle, so that each control command is taken once. The stimulus drives every access as a one-cycle strobe from a task, and only one task runs at a time. The reference pulse either stays high or pulses every third cycle, so divider periods change only at a command boundary. The stimulus also places an upload or a reset command before every start, so the counter never starts from a value left over from an earlier scenario.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int PRESC_W = 26;
    localparam int CNT_W   = 62;
    localparam int ALM_W   = 43;

    // word indexes (byte offset / 4)
    localparam int RI_CTRL  = 0;
    localparam int RI_MODE  = 1;
    localparam int RI_PRESC = 2;
    localparam int RI_ALO   = 3;
    localparam int RI_AHI   = 4;
    localparam int RI_MLO   = 5;
    localparam int RI_MHI   = 6;
    localparam int RI_TLO   = 8;
    localparam int RI_THI   = 9;

    // control word bit positions
    localparam int CB_START  = 0;
    localparam int CB_STOP   = 1;
    localparam int CB_ARM    = 2;
    localparam int CB_DISARM = 3;
    localparam int CB_CLEAR  = 4;
    localparam int CB_UPLOAD = 5;
    localparam int CB_MATCH  = 7;

    typedef struct packed {
        logic wake_cont;
        logic wake_rst;
        logic wake_en;
        logic cal;
    } mode_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic arm;
        logic disarm;
        logic clear;
        logic upload;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic wr, input logic [DATA_W-1:0] d);
        cmd_t c;
        c.start  = wr & d[CB_START];
        c.stop   = wr & d[CB_STOP];
        c.arm    = wr & d[CB_ARM];
        c.disarm = wr & d[CB_DISARM];
        c.clear  = wr & d[CB_CLEAR];
        c.upload = wr & d[CB_UPLOAD];
        return c;
    endfunction

    function automatic logic masked_eq(input logic [CNT_W-1:0] a,
                                       input logic [CNT_W-1:0] b,
                                       input logic [CNT_W-1:0] m);
        return ((a ^ b) & m) == '0;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PW = rtc_pkg::PRESC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          ref_en,
    input  logic          clr,
    input  logic [PW-1:0] limit,
    output logic          tick
);
    logic [PW-1:0] cnt_q;
    logic          at_end;

    // >= so that a limit lowered mid-period still ends the period
    assign at_end = cnt_q >= limit;
    assign tick   = run & ref_en & at_end;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run && ref_en) begin
            cnt_q <= at_end ? '0 : cnt_q + PW'(1);
        end
    end

    a_r2_wrap_after_tick: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt_q == '0);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!ref_en && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int W = rtc_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (ld) begin
            count <= ld_val;
        end else if (inc) begin
            count <= count + W'(1);
        end
    end

    a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0);

    a_r3_upload_loads: assert property (@(posedge clk) disable iff (rst)
        (ld && !clr) |=> count == $past(ld_val));

    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ld && !inc) |=> $stable(count));

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
    parameter int CW = rtc_pkg::CNT_W,
    parameter int AW = rtc_pkg::ALM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] alarm,
    input  logic [CW-1:0] mask,
    input  logic          running,
    input  logic          arm_set,
    input  logic          arm_clr,
    input  logic          wake_en,
    output logic          hit,
    output logic          match_q,
    output logic          irq
);
    logic          armed_q;
    logic [CW-1:0] alarm_ext;

    assign alarm_ext = {{(CW-AW){1'b0}}, alarm};
    assign hit       = running & rtc_pkg::masked_eq(count, alarm_ext, mask);
    assign irq       = match_q & armed_q & wake_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            match_q <= 1'b0;
        end else begin
            if (arm_clr)      armed_q <= 1'b0;
            else if (arm_set) armed_q <= 1'b1;

            if (arm_clr)      match_q <= 1'b0;
            else if (hit)     match_q <= 1'b1;
        end
    end

    a_r7_match_sticky: assert property (@(posedge clk) disable iff (rst)
        (match_q && !arm_clr) |=> match_q);

    a_r8_disarm_drops_irq: assert property (@(posedge clk) disable iff (rst)
        arm_clr |=> !irq);

    a_r7_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (hit && !arm_clr) |=> match_q);

endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
    import rtc_pkg::*;
#(
    parameter int AW_BUS  = rtc_pkg::ADDR_W,
    parameter int DW      = rtc_pkg::DATA_W,
    parameter int PW      = rtc_pkg::PRESC_W,
    parameter int CW      = rtc_pkg::CNT_W,
    parameter int ALW     = rtc_pkg::ALM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW_BUS-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq
);
    localparam int IDX_W    = AW_BUS - 2;
    localparam int CNT_HI_W = CW - DW;
    localparam int ALM_HI_W = ALW - DW;

    logic [IDX_W-1:0]    word_idx;
    logic                ctrl_wr;
    cmd_t                cmd;

    mode_t               mode_q;
    logic [PW-1:0]       presc_q;
    logic [DW-1:0]       alm_lo_q;
    logic [ALM_HI_W-1:0] alm_hi_q;
    logic [DW-1:0]       msk_lo_q;
    logic [CNT_HI_W-1:0] msk_hi_q;
    logic [DW-1:0]       stg_lo_q;
    logic [CNT_HI_W-1:0] stg_hi_q;
    logic [CNT_HI_W-1:0] snap_q;
    logic                running_q;
    logic                upl_q;
    logic [DW-1:0]       rdata_q;
    logic [DW-1:0]       rd_mux;

    logic [CW-1:0]       count;
    logic                tick;
    logic                hit;
    logic                match_q;
    logic                freeze;
    logic                wrap_hit;
    logic                cnt_clr;

    logic unused_addr_lsb;
    assign unused_addr_lsb = ^bus_addr[1:0];

    assign word_idx = bus_addr[AW_BUS-1:2];
    assign ctrl_wr  = bus_wr && (word_idx == IDX_W'(RI_CTRL));
    assign cmd      = decode_cmd(ctrl_wr, bus_wdata);

    // wake actions on a match
    assign freeze   = hit & mode_q.wake_en & ~mode_q.wake_rst & ~mode_q.wake_cont;
    assign wrap_hit = hit & mode_q.wake_en & mode_q.wake_rst;
    assign cnt_clr  = cmd.clear | (wrap_hit & ~cmd.upload);

    rtc_prescaler #(.PW(PW)) u_div (
        .clk    (clk),
        .rst    (rst),
        .run    (running_q & ~freeze),
        .ref_en (ref_en),
        .clr    (cmd.clear | cmd.upload),
        .limit  (presc_q),
        .tick   (tick)
    );

    rtc_sec_counter #(.W(CW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (cnt_clr),
        .ld     (cmd.upload),
        .ld_val ({stg_hi_q, stg_lo_q}),
        .inc    (tick),
        .count  (count)
    );

    rtc_alarm_unit #(.CW(CW), .AW(ALW)) u_alm (
        .clk     (clk),
        .rst     (rst),
        .count   (count),
        .alarm   ({alm_hi_q, alm_lo_q}),
        .mask    ({msk_hi_q, msk_lo_q}),
        .running (running_q),
        .arm_set (cmd.arm),
        .arm_clr (cmd.disarm),
        .wake_en (mode_q.wake_en),
        .hit     (hit),
        .match_q (match_q),
        .irq     (irq)
    );

    // run state and upload status
    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            upl_q     <= 1'b0;
        end else begin
            if (cmd.stop)       running_q <= 1'b0;
            else if (cmd.start) running_q <= 1'b1;
            else if (freeze)    running_q <= 1'b0;

            if (ctrl_wr)        upl_q <= cmd.upload;
        end
    end

    // configuration and staging registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            presc_q  <= '0;
            alm_lo_q <= '0;
            alm_hi_q <= '0;
            msk_lo_q <= '1;
            msk_hi_q <= '1;
            stg_lo_q <= '0;
            stg_hi_q <= '0;
        end else if (bus_wr) begin
            case (word_idx)
                IDX_W'(RI_MODE):  mode_q   <= mode_t'(bus_wdata[3:0]);
                IDX_W'(RI_PRESC): presc_q  <= bus_wdata[PW-1:0];
                IDX_W'(RI_ALO):   alm_lo_q <= bus_wdata;
                IDX_W'(RI_AHI):   alm_hi_q <= bus_wdata[ALM_HI_W-1:0];
                IDX_W'(RI_MLO):   msk_lo_q <= bus_wdata;
                IDX_W'(RI_MHI):   msk_hi_q <= bus_wdata[CNT_HI_W-1:0];
                IDX_W'(RI_TLO):   stg_lo_q <= bus_wdata;
                IDX_W'(RI_THI):   stg_hi_q <= bus_wdata[CNT_HI_W-1:0];
                default: ;
            endcase
        end
    end

    // read path
    always_comb begin
        rd_mux = '0;
        case (word_idx)
            IDX_W'(RI_CTRL): begin
                rd_mux[CB_START]  = running_q;
                rd_mux[CB_UPLOAD] = upl_q;
                rd_mux[CB_MATCH]  = match_q;
            end
            IDX_W'(RI_MODE):  rd_mux = DW'(mode_q);
            IDX_W'(RI_PRESC): rd_mux = DW'(presc_q);
            IDX_W'(RI_ALO):   rd_mux = alm_lo_q;
            IDX_W'(RI_AHI):   rd_mux = DW'(alm_hi_q);
            IDX_W'(RI_MLO):   rd_mux = msk_lo_q;
            IDX_W'(RI_MHI):   rd_mux = DW'(msk_hi_q);
            IDX_W'(RI_TLO):   rd_mux = count[DW-1:0];
            IDX_W'(RI_THI):   rd_mux = DW'(snap_q);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            snap_q  <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
            if (word_idx == IDX_W'(RI_TLO)) snap_q <= count[CW-1:DW];
        end
    end

    assign bus_rdata = rdata_q;

    a_r4_stop_wins: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[CB_STOP]) |=> !running_q);

    a_r4_start_runs: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && bus_wdata[CB_START] && !bus_wdata[CB_STOP]) |=> running_q);

    a_r11_halt_on_match: assert property (@(posedge clk) disable iff (rst)
        (freeze && !ctrl_wr) |=> (!running_q && $stable(count)));

    a_r10_restart_zero: assert property (@(posedge clk) disable iff (rst)
        (wrap_hit && !ctrl_wr) |=> count == '0);

    a_r6_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/rtc_seconds_core_test.sv
`timescale 1ns/1ps
module rtc_seconds_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_en = 1'b1;
    logic        b_wr = 1'b0;
    logic        b_rd = 1'b0;
    logic [5:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int ph = 0;
    bit ref_pat = 1'b0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_seconds_core uut (
        .clk(clk), .rst(rst), .ref_en(ref_en), .bus_wr(b_wr), .bus_rd(b_rd),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rdata), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [61:0] m_cnt;
    logic [25:0] m_pc, m_ps;
    logic        m_run, m_arm, m_match, m_upl;
    logic [3:0]  m_mode;
    logic [31:0] m_alo, m_klo, m_slo, m_rd;
    logic [10:0] m_ahi;
    logic [29:0] m_khi, m_shi, m_snap;

    always @(posedge clk) begin : model
        logic [61:0] alm, msk;
        logic hit, frz, wrh, tick, cw, adv;
        logic [31:0] d;
        if (rst) begin
            m_cnt = '0; m_pc = '0; m_ps = '0; m_run = 0; m_arm = 0; m_match = 0;
            m_upl = 0; m_mode = '0; m_alo = '0; m_ahi = '0; m_klo = '1; m_khi = '1;
            m_slo = '0; m_shi = '0; m_snap = '0; m_rd = '0;
        end else begin
            d   = b_wdata;
            alm = {19'd0, m_ahi, m_alo};
            msk = {m_khi, m_klo};
            hit = m_run && (((m_cnt ^ alm) & msk) == 62'd0);
            frz = hit && m_mode[1] && !m_mode[2] && !m_mode[3];
            wrh = hit && m_mode[1] && m_mode[2];
            adv = m_run && !frz && ref_en;
            tick = adv && (m_pc >= m_ps);
            cw  = b_wr && (b_addr[5:2] == 4'd0);
            if (b_rd) begin
                case (b_addr[5:2])
                    4'd0: m_rd = {24'd0, m_match, 1'b0, m_upl, 4'd0, m_run};
                    4'd1: m_rd = {28'd0, m_mode};
                    4'd2: m_rd = {6'd0, m_ps};
                    4'd3: m_rd = m_alo;
                    4'd4: m_rd = {21'd0, m_ahi};
                    4'd5: m_rd = m_klo;
                    4'd6: m_rd = {2'd0, m_khi};
                    4'd8: begin m_rd = m_cnt[31:0]; m_snap = m_cnt[61:32]; end
                    4'd9: m_rd = {2'd0, m_snap};
                    default: m_rd = '0;
                endcase
            end
            if (cw && d[4])      m_cnt = '0;
            else if (cw && d[5]) m_cnt = {m_shi, m_slo};
            else if (wrh)        m_cnt = '0;
            else if (tick)       m_cnt = m_cnt + 62'd1;
            if (cw && (d[4] || d[5])) m_pc = '0;
            else if (adv)             m_pc = (m_pc >= m_ps) ? 26'd0 : m_pc + 26'd1;
            if (cw && d[3]) begin m_arm = 0; m_match = 0; end
            else begin
                if (cw && d[2]) m_arm = 1;
                if (hit) m_match = 1;
            end
            if (cw) m_upl = d[5];
            if (cw && d[1])      m_run = 0;
            else if (cw && d[0]) m_run = 1;
            else if (frz)        m_run = 0;
            if (b_wr) begin
                case (b_addr[5:2])
                    4'd1: m_mode = d[3:0];
                    4'd2: m_ps = d[25:0];
                    4'd3: m_alo = d;
                    4'd4: m_ahi = d[10:0];
                    4'd5: m_klo = d;
                    4'd6: m_khi = d[29:0];
                    4'd8: m_slo = d;
                    4'd9: m_shi = d[29:0];
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // every clock: interrupt (R8) and read data (R6) against the model
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(irq === (m_match & m_arm & m_mode[1]), "R8 irq per cycle",
                {63'd0, irq}, {63'd0, m_match & m_arm & m_mode[1]});
            chk(rdata === m_rd, "R6 read data per cycle", {32'd0, rdata}, {32'd0, m_rd});
        end
    end

    always @(negedge clk) begin
        ph++;
        ref_en <= ref_pat ? (ph % 3 == 0) : 1'b1;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); b_wr = 1; b_addr = a; b_wdata = d;
        @(negedge clk); b_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        @(negedge clk); b_rd = 1; b_addr = a;
        @(negedge clk); b_rd = 0;
        chk(rdata === m_rd, tag, {32'd0, rdata}, {32'd0, m_rd});
    endtask

    task automatic rd_exp(input logic [5:0] a, input logic [31:0] e, input string tag);
        rd(a, tag);
        chk(rdata === e, tag, {32'd0, rdata}, {32'd0, e});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        cmp_on = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        rd_exp(6'h00, 32'h0, "R1 control after reset");
        rd_exp(6'h04, 32'h0, "R1 mode after reset");
        rd_exp(6'h18, 32'h3FFF_FFFF, "R1 mask high after reset");
        rd_exp(6'h14, 32'hFFFF_FFFF, "R1 mask low after reset");
        rd_exp(6'h20, 32'h0, "R1 count after reset");
        chk(irq === 1'b0, "R1 irq after reset", {63'd0, irq}, 64'd0);

        // R2 divider width
        wr(6'h08, 32'hFFFF_FFFF);
        rd_exp(6'h08, 32'h03FF_FFFF, "R2 divider readback width");
        wr(6'h08, 32'd4);

        // R3 upload
        wr(6'h20, 32'd5);
        wr(6'h24, 32'hC000_0001);
        wr(6'h00, 32'h20);
        rd_exp(6'h00, 32'h20, "R3 upload status bit");
        rd_exp(6'h20, 32'd5, "R3 uploaded low half");
        rd_exp(6'h24, 32'd1, "R3 uploaded high half");

        // R4 start/stop
        wr(6'h00, 32'h03);
        rd_exp(6'h00, 32'h0, "R4 stop wins over start");
        idle(10);
        rd_exp(6'h20, 32'd5, "R4 stopped counter holds");
        wr(6'h00, 32'h01);
        idle(50);
        rd(6'h20, "R2 divide by five");
        rd_exp(6'h00, 32'h01, "R4 running flag");
        ref_pat = 1;
        idle(60);
        rd(6'h20, "R2 sparse reference pulses");
        ref_pat = 0;
        wr(6'h00, 32'h00);
        rd_exp(6'h00, 32'h01, "R4 empty write keeps running");
        wr(6'h00, 32'h02);
        idle(5);
        rd(6'h20, "R4 after stop");
        idle(10);
        rd(6'h20, "R4 hold after stop");

        // R5 clear command beats upload
        wr(6'h00, 32'h30);
        rd_exp(6'h20, 32'd0, "R5 clear low");
        rd_exp(6'h24, 32'd0, "R5 clear high");

        // R6 snapshot across a carry
        wr(6'h08, 32'd0);
        wr(6'h20, 32'hFFFF_FFFE);
        wr(6'h24, 32'd2);
        wr(6'h00, 32'h20);
        wr(6'h00, 32'h01);
        rd(6'h20, "R6 low half");
        idle(3);
        rd(6'h24, "R6 captured high half");
        wr(6'h00, 32'h02);

        // R12 ignored bits, unmapped offset, calendar bit
        wr(6'h00, 32'h740);
        rd_exp(6'h00, 32'h0, "R12 ignored command bits");
        rd_exp(6'h1C, 32'h0, "R12 unmapped offset");
        wr(6'h04, 32'h1);
        rd_exp(6'h04, 32'h1, "R12 calendar bit stored");

        // R11 halt on match
        wr(6'h00, 32'h10);
        wr(6'h0C, 32'd20);
        wr(6'h10, 32'd0);
        wr(6'h04, 32'h2);
        wr(6'h20, 32'd10);
        wr(6'h24, 32'd0);
        wr(6'h00, 32'h20);
        wr(6'h00, 32'h01);
        idle(30);
        rd_exp(6'h20, 32'd20, "R11 halted at alarm value");
        rd_exp(6'h00, 32'h80, "R7 match flag set, R11 run cleared");
        chk(irq === 1'b0, "R8 irq low while disarmed", {63'd0, irq}, 64'd0);
        wr(6'h00, 32'h04);
        chk(irq === 1'b1, "R8 irq after arm", {63'd0, irq}, 64'd1);
        wr(6'h00, 32'h0C);
        chk(irq === 1'b0, "R8 disarm wins", {63'd0, irq}, 64'd0);
        rd_exp(6'h00, 32'h0, "R8 match cleared by disarm");

        // R9 continue through match
        wr(6'h0C, 32'd30);
        wr(6'h04, 32'hA);
        wr(6'h00, 32'h04);
        wr(6'h00, 32'h20);
        wr(6'h00, 32'h01);
        idle(40);
        rd(6'h20, "R9 keeps counting");
        chk(rdata > 32'd30, "R9 count passed alarm", {32'd0, rdata}, 64'd31);
        wr(6'h00, 32'h0A);

        // R10 restart (priority over continue)
        wr(6'h08, 32'd3);
        wr(6'h0C, 32'd25);
        wr(6'h04, 32'hE);
        wr(6'h20, 32'd20);
        wr(6'h00, 32'h20);
        wr(6'h00, 32'h05);
        idle(30);
        rd(6'h20, "R10 restarted from zero");
        chk(rdata < 32'd25, "R10 count below alarm", {32'd0, rdata}, 64'd24);
        wr(6'h00, 32'h0A);

        // R7 masked compare
        wr(6'h08, 32'd0);
        wr(6'h14, 32'hF);
        wr(6'h18, 32'd0);
        wr(6'h0C, 32'd5);
        wr(6'h04, 32'hA);
        wr(6'h20, 32'h100);
        wr(6'h00, 32'h20);
        wr(6'h00, 32'h05);
        idle(10);
        rd(6'h00, "R7 masked match");
        chk(rdata[7] === 1'b1, "R7 match bit under mask", {63'd0, rdata[7]}, 64'd1);

        // R8/R11 without wake enable
        wr(6'h00, 32'h0A);
        wr(6'h04, 32'h0);
        wr(6'h00, 32'h05);
        idle(40);
        chk(irq === 1'b0, "R8 no irq without wake enable", {63'd0, irq}, 64'd0);
        rd(6'h00, "R11 match flag without wake");
        rd(6'h20, "R11 no halt without wake enable");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule